// File: doc/BRIEF.md
# Sigma-Delta ADC Serial Transaction Engine

This block is the serial-bus master that sits between on-chip logic and an external sigma-delta converter whose data output pin also signals "conversion finished". A client hands it one command at a time over a valid/ready handshake: write a converter register, read a converter register, or run a complete single conversion on a chosen channel and fetch the result. Each bus frame opens with a command byte that carries the register address and a read flag. One to three payload bytes follow, most significant first.

A conversion is a three-frame sequence. The engine writes the configuration register with the requested channel, then writes the mode register to request a single conversion. It keeps chip select asserted and watches the shared data/ready line until it goes low. It then reads the result register in the same chip-select frame and returns the value with a one-cycle done pulse. While chip select is held, no other command is accepted, so nothing disturbs the ready signal. A run-time limit ends the wait with an error if the converter never reports ready.

Top module: `sdadc_spi_engine`

## Requirements
- R1: The first byte of every frame is a command byte: bit 7 = 0, bit 6 = 1 for a read and 0 for a write, bits 5:3 = register address, bits 2:0 = 0.
- R2: `cmd_len` gives the payload size in bytes (1, 2 or 3), sent most significant byte first. A command with `cmd_len` = 0, or with `cmd_op` = 3, is accepted and answered with `rsp_done` and `rsp_err` in the next cycle, and chip select never asserts.
- R3: A register read (`cmd_op` = 1) sends the command byte and then clocks in `cmd_len` bytes within one chip-select frame. The value is returned right-aligned in `rsp_data`.
- R4: The serial clock runs in mode 3. It idles high whenever chip select is released, and its half period is `CLK_HALF` system cycles. MOSI changes only on falling edges, and MISO is sampled on rising edges.
- R5: A conversion (`cmd_op` = 2) first writes address 2 with two bytes, equal to `cmd_wdata[15:0]` with bits 2:0 replaced by `cmd_chan`. Chip select is then released.
- R6: The second conversion frame writes address 1 with two bytes whose bits 15:13 are 001 (single conversion). Chip select stays asserted after that frame.
- R7: Once MISO is seen low, the engine sends a read command for address 3 in the still-open frame and reads `cmd_len` bytes. It then releases chip select and pulses `rsp_done` with `rsp_err` = 0.
- R8: While chip select is asserted, `cmd_ready` is low, so no command can reach the bus.
- R9: In the ready wait, the engine checks MISO once per cycle. If MISO has not been seen low by the (`rdy_timeout`+1)-th check, it releases chip select and pulses `rsp_done` with `rsp_err` = 1. A low level seen at that same check is taken as ready, not as a timeout.
- R10: A command is taken when `cmd_valid` and `cmd_ready` are both high. Acceptance clears `rsp_data` and `rsp_err`. `rsp_done` lasts one cycle, and `rsp_data` and `rsp_err` hold their values until the next acceptance.
- R11: After reset, `spi_cs_n` = 1, `spi_sclk` = 1, `cmd_ready` = 1, `rsp_done` = 0 and `rsp_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 2 | 0 write, 1 read, 2 convert, 3 rejected |
| cmd_addr | input | 3 | Register address for write/read |
| cmd_len | input | 2 | Payload or result length in bytes |
| cmd_wdata | input | 24 | Write payload; for convert, the configuration word in bits 15:0 |
| cmd_chan | input | 3 | Channel code for a conversion |
| rdy_timeout | input | 16 | Ready-wait limit in cycles |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Error flag, valid from `rsp_done` on |
| rsp_data | output | 24 | Read or conversion result, right-aligned |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, mode 3 |
| spi_mosi | output | 1 | Serial data to converter |
| spi_miso | input | 1 | Serial data from converter, also ready flag |

## Verification
Two functions can fall in the same cycle: the ready wait's timeout expiring and the converter pulling the shared line low. The bench models the converter with a programmable delay from the end of the mode write to the ready edge. It sets that delay to exactly `rdy_timeout`+1 cycles and then to one cycle more. The first case must return the conversion result without error. The second must end in the error response with chip select released and zero data.

// File: rtl/sdadc_pkg.sv
package sdadc_pkg;
  localparam int BYTE_W    = 8;
  localparam int MAX_BYTES = 3;
  localparam int WORD_W    = BYTE_W * MAX_BYTES;
  localparam int ADDR_W    = 3;

  typedef enum logic [1:0] {
    OP_WRITE   = 2'd0,
    OP_READ    = 2'd1,
    OP_CONVERT = 2'd2,
    OP_BAD     = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SEND,
    ST_SHIFT,
    ST_GAP,
    ST_WAIT
  } st_e;

  // One bus frame: command byte, payload count and routing flags
  typedef struct packed {
    logic [BYTE_W-1:0] cmd;
    logic [1:0]        len;
    logic [WORD_W-1:0] payload;
    logic              is_read;
    logic              hold_cs;
  } frame_t;
endpackage

// File: rtl/sdadc_frame_plan.sv
module sdadc_frame_plan import sdadc_pkg::*; #(
  parameter int                CHAN_W     = 3,
  parameter logic [ADDR_W-1:0] CONF_ADDR  = 3'd2,
  parameter logic [ADDR_W-1:0] MODE_ADDR  = 3'd1,
  parameter logic [ADDR_W-1:0] DATA_ADDR  = 3'd3,
  parameter logic [2:0]        SEL_SINGLE = 3'b001,
  parameter logic [12:0]       MODE_REST  = 13'h000A
) (
  input  op_e                op,
  input  logic [1:0]         phase,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [1:0]         len,
  input  logic [WORD_W-1:0]  wdata,
  input  logic [CHAN_W-1:0]  chan,
  output frame_t             frame
);
  function automatic logic [BYTE_W-1:0] cmd_byte(input logic rd, input logic [ADDR_W-1:0] a);
    return {1'b0, rd, a, 3'b000};
  endfunction

  logic [15:0] conf_word;
  logic [15:0] mode_word;

  assign conf_word = {wdata[15:CHAN_W], chan};
  assign mode_word = {SEL_SINGLE, MODE_REST};

  always_comb begin
    frame = '0;
    unique case (op)
      OP_WRITE: begin
        frame.cmd     = cmd_byte(1'b0, addr);
        frame.len     = len;
        frame.payload = wdata;
      end
      OP_READ: begin
        frame.cmd     = cmd_byte(1'b1, addr);
        frame.len     = len;
        frame.is_read = 1'b1;
      end
      OP_CONVERT: begin
        unique case (phase)
          2'd0: begin
            frame.cmd     = cmd_byte(1'b0, CONF_ADDR);
            frame.len     = 2'd2;
            frame.payload = {{(WORD_W-16){1'b0}}, conf_word};
          end
          2'd1: begin
            frame.cmd     = cmd_byte(1'b0, MODE_ADDR);
            frame.len     = 2'd2;
            frame.payload = {{(WORD_W-16){1'b0}}, mode_word};
            frame.hold_cs = 1'b1;
          end
          default: begin
            frame.cmd     = cmd_byte(1'b1, DATA_ADDR);
            frame.len     = len;
            frame.is_read = 1'b1;
          end
        endcase
      end
      default: frame = '0;
    endcase
  end
endmodule

// File: rtl/sdadc_byte_engine.sv
module sdadc_byte_engine import sdadc_pkg::*; #(
  parameter int CLK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              done,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int CW = $clog2(CLK_HALF + 1);
  localparam int BW = $clog2(BYTE_W);

  logic              busy;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bitn;
  logic [BYTE_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cnt     <= '0;
      bitn    <= '0;
      sh      <= '0;
      sclk    <= 1'b1;
      mosi    <= 1'b1;
      done    <= 1'b0;
      rx_byte <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          sh   <= tx_byte;
          cnt  <= '0;
          bitn <= '0;
        end
      end else if (cnt == CW'(CLK_HALF - 1)) begin
        cnt <= '0;
        if (sclk) begin
          // falling edge: present next bit
          sclk <= 1'b0;
          mosi <= sh[BYTE_W-1];
          sh   <= {sh[BYTE_W-2:0], 1'b0};
        end else begin
          // rising edge: capture incoming bit
          sclk    <= 1'b1;
          rx_byte <= {rx_byte[BYTE_W-2:0], miso};
          bitn    <= bitn + 1'b1;
          if (bitn == BW'(BYTE_W - 1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdadc_spi_engine.sv
module sdadc_spi_engine import sdadc_pkg::*; #(
  parameter int                CLK_HALF   = 2,
  parameter int                TMO_W      = 16,
  parameter int                CHAN_W     = 3,
  parameter logic [ADDR_W-1:0] CONF_ADDR  = 3'd2,
  parameter logic [ADDR_W-1:0] MODE_ADDR  = 3'd1,
  parameter logic [ADDR_W-1:0] DATA_ADDR  = 3'd3,
  parameter logic [12:0]       MODE_REST  = 13'h000A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [2:0]        cmd_addr,
  input  logic [1:0]        cmd_len,
  input  logic [23:0]       cmd_wdata,
  input  logic [2:0]        cmd_chan,
  input  logic [15:0]       rdy_timeout,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [23:0]       rsp_data,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int GAP   = 2 * CLK_HALF;
  localparam int GAP_W = $clog2(GAP + 1);

  st_e                state;
  op_e                op_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [1:0]         len_q;
  logic [1:0]         phase;
  logic [1:0]         byte_idx;
  logic [WORD_W-1:0]  wdata_q;
  logic [WORD_W-1:0]  pay_sh;
  logic [CHAN_W-1:0]  chan_q;
  logic [TMO_W-1:0]   tmo_lim;
  logic [TMO_W-1:0]   tmo_cnt;
  logic [GAP_W-1:0]   gap_cnt;

  frame_t             plan;
  logic               eng_start;
  logic               eng_done;
  logic [BYTE_W-1:0]  eng_tx;
  logic [BYTE_W-1:0]  eng_rx;

  sdadc_frame_plan #(
    .CHAN_W    (CHAN_W),
    .CONF_ADDR (CONF_ADDR),
    .MODE_ADDR (MODE_ADDR),
    .DATA_ADDR (DATA_ADDR),
    .SEL_SINGLE(3'b001),
    .MODE_REST (MODE_REST)
  ) u_plan (
    .op    (op_q),
    .phase (phase),
    .addr  (addr_q),
    .len   (len_q),
    .wdata (wdata_q),
    .chan  (chan_q),
    .frame (plan)
  );

  sdadc_byte_engine #(.CLK_HALF(CLK_HALF)) u_eng (
    .clk     (clk),
    .rst     (rst),
    .start   (eng_start),
    .tx_byte (eng_tx),
    .miso    (spi_miso),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .done    (eng_done),
    .rx_byte (eng_rx)
  );

  assign cmd_ready = (state == ST_IDLE);
  assign eng_start = (state == ST_SEND);
  assign eng_tx    = (byte_idx == 2'd0) ? plan.cmd :
                     plan.is_read       ? '0 : pay_sh[WORD_W-1 -: BYTE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      op_q     <= OP_WRITE;
      addr_q   <= '0;
      len_q    <= '0;
      phase    <= '0;
      byte_idx <= '0;
      wdata_q  <= '0;
      pay_sh   <= '0;
      chan_q   <= '0;
      tmo_lim  <= '0;
      tmo_cnt  <= '0;
      gap_cnt  <= '0;
      spi_cs_n <= 1'b1;
      rsp_done <= 1'b0;
      rsp_err  <= 1'b0;
      rsp_data <= '0;
    end else begin
      rsp_done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            op_q     <= op_e'(cmd_op);
            addr_q   <= cmd_addr;
            len_q    <= cmd_len;
            wdata_q  <= cmd_wdata;
            chan_q   <= cmd_chan[CHAN_W-1:0];
            tmo_lim  <= rdy_timeout[TMO_W-1:0];
            phase    <= 2'd0;
            rsp_data <= '0;
            rsp_err  <= 1'b0;
            if (cmd_len == 2'd0 || op_e'(cmd_op) == OP_BAD) begin
              rsp_err  <= 1'b1;
              rsp_done <= 1'b1;
            end else begin
              state <= ST_LOAD;
            end
          end
        end
        ST_LOAD: begin
          pay_sh   <= plan.payload << (BYTE_W * (MAX_BYTES - int'(plan.len)));
          byte_idx <= 2'd0;
          spi_cs_n <= 1'b0;
          state    <= ST_SEND;
        end
        ST_SEND: begin
          if (byte_idx != 2'd0 && !plan.is_read)
            pay_sh <= pay_sh << BYTE_W;
          state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (eng_done) begin
            if (plan.is_read && byte_idx != 2'd0)
              rsp_data <= {rsp_data[WORD_W-BYTE_W-1:0], eng_rx};
            if (byte_idx == plan.len) begin
              if (op_q == OP_CONVERT && phase == 2'd0) begin
                spi_cs_n <= 1'b1;
                gap_cnt  <= '0;
                state    <= ST_GAP;
              end else if (plan.hold_cs) begin
                tmo_cnt <= '0;
                state   <= ST_WAIT;
              end else begin
                spi_cs_n <= 1'b1;
                rsp_done <= 1'b1;
                state    <= ST_IDLE;
              end
            end else begin
              byte_idx <= byte_idx + 1'b1;
              state    <= ST_SEND;
            end
          end
        end
        ST_GAP: begin
          if (gap_cnt == GAP_W'(GAP - 1)) begin
            phase <= 2'd1;
            state <= ST_LOAD;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        ST_WAIT: begin
          if (!spi_miso) begin
            phase <= 2'd2;
            state <= ST_LOAD;
          end else if (tmo_cnt == tmo_lim) begin
            spi_cs_n <= 1'b1;
            rsp_err  <= 1'b1;
            rsp_done <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            tmo_cnt <= tmo_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdadc_spi_engine_chk.sv
module sdadc_spi_engine_chk (
  input logic        clk,
  input logic        rst,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [1:0]  cmd_op,
  input logic [1:0]  cmd_len,
  input logic        rsp_done,
  input logic        rsp_err,
  input logic [23:0] rsp_data,
  input logic        spi_cs_n,
  input logic        spi_sclk,
  input logic        spi_mosi
);
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  // R4
  sclk_idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> spi_sclk);

  // R4
  mosi_on_fall_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (!spi_cs_n && spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  // R8
  bus_locked_chk: assert property (@(posedge clk) disable iff (rst)
    !spi_cs_n |-> !cmd_ready);

  // R2
  bad_len_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_len == 2'd0) |=> (rsp_done && rsp_err && spi_cs_n));

  // R9
  done_released_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> spi_cs_n);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (cmd_ready && $past(cmd_ready) && !$past(cmd_valid)) |-> ($stable(rsp_data) && $stable(rsp_err)));

  // R2
  bad_op_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_op == 2'd3) |=> (rsp_done && rsp_err));
endmodule

bind sdadc_spi_engine sdadc_spi_engine_chk u_chk (.*);

// File: tb/sdadc_spi_engine_test.sv
`timescale 1ns/1ps
module sdadc_spi_engine_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'd0;
  logic [2:0]  cmd_addr = 3'd0;
  logic [1:0]  cmd_len = 2'd1;
  logic [23:0] cmd_wdata = 24'd0;
  logic [2:0]  cmd_chan = 3'd0;
  logic [15:0] rdy_timeout = 16'd1000;
  logic        rsp_done, rsp_err;
  logic [23:0] rsp_data;
  logic        spi_cs_n, spi_sclk, spi_mosi, spi_miso;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sdadc_spi_engine uut (
    .clk, .rst, .cmd_valid, .cmd_ready, .cmd_op, .cmd_addr, .cmd_len,
    .cmd_wdata, .cmd_chan, .rdy_timeout, .rsp_done, .rsp_err, .rsp_data,
    .spi_cs_n, .spi_sclk, .spi_mosi, .spi_miso
  );

  // ---------------- converter model ----------------
  logic [23:0] mreg [8];
  logic [7:0]  last_cmd;
  int          dbytes = 3;
  int          conv_delay = 10;
  logic        conv_arm = 1'b0;
  int          waited = 0;
  logic        drv = 1'b0;
  logic        dbit = 1'b1;
  int          cs_falls = 0;
  int          cs_rises = 0;

  function automatic int reg_width(input logic [2:0] a);
    case (a)
      3'd1, 3'd2: return 2;
      3'd3:       return dbytes;
      3'd7:       return 3;
      default:    return 1;
    endcase
  endfunction

  function automatic logic [23:0] lmask(input int n);
    return (n >= 3) ? 24'hFFFFFF : ((24'd1 << (8 * n)) - 24'd1);
  endfunction

  function automatic logic [23:0] conv_val(input logic [2:0] ch, input int n);
    return (24'h3C5A96 + 24'(ch) * 24'h010203) & lmask(n);
  endfunction

  assign spi_miso = drv ? dbit : ~(conv_arm && (waited >= conv_delay));

  always @(posedge clk) begin
    if (!conv_arm) waited <= 0;
    else           waited <= waited + 1;
  end

  always @(negedge spi_cs_n) cs_falls++;
  always @(posedge spi_cs_n) cs_rises++;

  task automatic slave_byte(output logic [7:0] b, output bit ok);
    b  = '0;
    ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(posedge spi_sclk or posedge spi_cs_n);
      if (spi_cs_n) begin
        ok = 1'b0;
        return;
      end
      b = {b[6:0], spi_mosi};
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mreg[i] = '0;
    last_cmd = '0;
    forever begin
      @(negedge spi_cs_n);
      while (!spi_cs_n) begin
        logic [7:0] cb;
        bit ok;
        int n;
        slave_byte(cb, ok);
        if (!ok) break;
        last_cmd = cb;
        n = reg_width(cb[5:3]);
        if (cb[6]) begin
          logic [23:0] v;
          v = (cb[5:3] == 3'd3) ? conv_val(mreg[2][2:0], dbytes) : (mreg[cb[5:3]] & lmask(n));
          for (int i = 0; i < 8 * n; i++) begin
            @(negedge spi_sclk or posedge spi_cs_n);
            if (spi_cs_n) break;
            drv  = 1'b1;
            dbit = v[8*n-1-i];
            @(posedge spi_sclk or posedge spi_cs_n);
            if (spi_cs_n) break;
          end
          drv = 1'b0;
          if (cb[5:3] == 3'd3) conv_arm = 1'b0;
        end else begin
          logic [23:0] acc;
          acc = '0;
          for (int k = 0; k < n; k++) begin
            logic [7:0] bb;
            slave_byte(bb, ok);
            if (!ok) break;
            acc = {acc[15:0], bb};
          end
          if (ok) begin
            mreg[cb[5:3]] = acc;
            if (cb[5:3] == 3'd1 && acc[15:13] == 3'b001) begin
              #1 conv_arm = 1'b1;
            end
          end
        end
      end
      drv      = 1'b0;
      conv_arm = 1'b0;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [2:0] a, input logic [1:0] len,
                       input logic [23:0] wd, input logic [2:0] ch);
    @(negedge clk);
    cmd_op    = op;
    cmd_addr  = a;
    cmd_len   = len;
    cmd_wdata = wd;
    cmd_chan  = ch;
    cmd_valid = 1'b1;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (rsp_done) return;
    end
    checks++;
    fails++;
    $display("FAIL R10: no done pulse, actual 0 expected 1");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [23:0] wd;
    logic [2:0]  a;
    int f0, r0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 cs_n",  32'(spi_cs_n), 32'd1);
    check("R11 sclk",  32'(spi_sclk), 32'd1);
    check("R11 ready", 32'(cmd_ready), 32'd1);
    check("R11 done",  32'(rsp_done), 32'd0);
    check("R11 data",  32'(rsp_data), 32'd0);

    // R1 R2 write sweep over lengths and patterns
    for (int len = 1; len <= 3; len++) begin
      for (int p = 0; p < 4; p++) begin
        a  = (len == 1) ? 3'd0 : (len == 2) ? 3'd2 : 3'd7;
        wd = 24'h123456 ^ (24'(p) * 24'h1F2E3D);
        issue(2'd0, a, 2'(len), wd, 3'd0);
        wait_done();
        check("R1 write command byte", 32'(last_cmd), 32'({2'b00, a, 3'b000}));
        check("R2 write payload", 32'(mreg[a]), 32'(wd & lmask(len)));
        check("R2 write no error", 32'(rsp_err), 32'd0);
        // R3 read back
        issue(2'd1, a, 2'(len), 24'hFFFFFF, 3'd0);
        wait_done();
        check("R1 read command byte", 32'(last_cmd), 32'({2'b01, a, 3'b000}));
        check("R3 read data", 32'(rsp_data), 32'(wd & lmask(len)));
        repeat (20) @(negedge clk);
        check("R10 data held", 32'(rsp_data), 32'(wd & lmask(len)));
      end
    end

    // R2 rejections
    f0 = cs_falls;
    issue(2'd0, 3'd4, 2'd0, 24'h0000AA, 3'd0);
    wait_done();
    check("R2 zero length error", 32'(rsp_err), 32'd1);
    check("R10 data cleared", 32'(rsp_data), 32'd0);
    issue(2'd3, 3'd4, 2'd2, 24'h0000AA, 3'd0);
    wait_done();
    check("R2 bad op error", 32'(rsp_err), 32'd1);
    repeat (10) @(negedge clk);
    check("R2 no chip select", 32'(cs_falls - f0), 32'd0);

    // R5 R6 R7 R8 conversion sweep
    conv_delay  = 37;
    rdy_timeout = 16'd1000;
    for (int w = 2; w <= 3; w++) begin
      dbytes = w;
      for (int ch = 0; ch < 8; ch++) begin
        wd = 24'h00C35F ^ (24'(ch) << 8);
        f0 = cs_falls;
        r0 = cs_rises;
        issue(2'd2, 3'd0, 2'(w), wd, 3'(ch));
        for (int i = 0; i < 5000; i++) begin
          @(negedge clk);
          if (conv_arm) break;
        end
        check("R8 ready low while held", 32'(cmd_ready), 32'd0);
        check("R6 cs held after mode write", 32'(spi_cs_n), 32'd0);
        wait_done();
        check("R5 configuration word", 32'(mreg[2][15:0]), 32'({wd[15:3], 3'(ch)}));
        check("R6 single select", 32'(mreg[1][15:13]), 32'd1);
        check("R7 result", 32'(rsp_data), 32'(conv_val(3'(ch), w)));
        check("R7 no error", 32'(rsp_err), 32'd0);
        check("R7 frames", 32'((cs_falls - f0) * 16 + (cs_rises - r0)), 32'h22);
        check("R7 cs released", 32'(spi_cs_n), 32'd1);
      end
    end

    // R9 ready on the very check where the limit expires
    dbytes      = 3;
    rdy_timeout = 16'd20;
    conv_delay  = 21;
    issue(2'd2, 3'd0, 2'd3, 24'h000010, 3'd5);
    wait_done();
    check("R9 coincident ready wins", 32'(rsp_err), 32'd0);
    check("R9 coincident result", 32'(rsp_data), 32'(conv_val(3'd5, 3)));

    // R9 one cycle late: timeout
    conv_delay = 22;
    issue(2'd2, 3'd0, 2'd3, 24'h000010, 3'd6);
    wait_done();
    check("R9 timeout error", 32'(rsp_err), 32'd1);
    check("R9 timeout data", 32'(rsp_data), 32'd0);
    check("R9 timeout release", 32'(spi_cs_n), 32'd1);

    // R9 never ready
    conv_delay = 1000000;
    issue(2'd2, 3'd0, 2'd2, 24'h000000, 3'd1);
    wait_done();
    check("R9 never ready", 32'(rsp_err), 32'd1);
    repeat (10) @(negedge clk);
    check("R9 ready restored", 32'(cmd_ready), 32'd1);

    // R4 bus still usable in mode 3 after errors
    issue(2'd0, 3'd7, 2'd3, 24'hA1B2C3, 3'd0);
    wait_done();
    check("R4 transfer after timeout", 32'(mreg[7]), 32'hA1B2C3);
    check("R4 sclk idle high", 32'(spi_sclk), 32'd1);

    finish_run();
  end
endmodule